// File: doc/BRIEF.md
# Memory-Mapped Bidirectional GPIO Port

This block is an eight-pin general-purpose I/O port that sits on a simple byte-wide peripheral bus. Software uses three byte registers. The output latch holds the level each pin drives. The direction register picks input or output for each pin. The pull-inhibit register lets software switch off each pin's pull device. The block does not drive pads itself. It produces per-pin output enables, output levels and pull enables, plus a slow-falling-edge request for the two upper pins, for a pad ring to use.

Pin levels pass through a two-flop synchronizer before any logic uses them. The synchronized levels serve register reads and an active-low interrupt tap. The two upper pins are open-drain: they can pull their pad low, or release it. The output latch has no reset, so a value written before a reset is still there afterwards. The direction and pull-inhibit registers clear on reset.

Top module: `gpio_bidir_port`

## Requirements
- R1: A bus write (`bus_sel`=1, `bus_we`=1) to offset 0x00 loads the output latch, to 0x04 loads the direction register, and to 0x10 loads the pull-inhibit register. Each takes effect on the clock edge of the write. A read of 0x04 returns the direction register.
- R2: A direction bit of 1 makes its pin an output and 0 makes it an input. For push-pull pins 0 to 5, `pin_oe` equals the direction bit and `pin_out` equals the latch bit.
- R3: Reset (`rst_n`=0, asynchronous) clears the direction and pull-inhibit registers to 0x00. The output latch keeps its value through reset.
- R4: A read of offset 0x00 returns the latch bit for pins set as outputs, and the synchronized pin level for pins set as inputs.
- R5: Pins 6 and 7 are open-drain. `pin_out` is always 0 for them. `pin_oe` is 1 only when the pin is an output and its latch bit is 0.
- R6: `slow_fall` bits 6 and 7 are 1 only when `slow_edge_en` is 1 and that pin is an output. Bits 0 to 5 of `slow_fall` are always 0.
- R7: `pull_en` for a pin is 1 only when its pull-inhibit bit is 0 and the pin is an input.
- R8: The pull-inhibit register is write-only, and a read of 0x10 returns 0x00. Reads of any offset other than 0x00 and 0x04, and reads with `bus_sel`=0, return 0x00. Writes to unmapped offsets change no register.
- R9: `irq_n` is 0 when any of synchronized pins 0, 1, 2, 3 or 7 is low, and 1 otherwise. Pins 4, 5 and 6 have no effect on it.
- R10: A change on `pin_in` reaches the read data and `irq_n` after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pin_oe | output | 8 | Pad output enables |
| pin_out | output | 8 | Pad output levels |
| pull_en | output | 8 | Pad pull device enables |
| slow_edge_en | input | 1 | Slow falling-edge control from outside the port |
| slow_fall | output | 8 | Per-pin slow falling-edge request |
| irq_n | output | 1 | Active-low interrupt tap |

## Verification
The bench writes the latch, pulses reset, then turns the pins to outputs and reads the latch back. A design that reset the latch would return 0x00 here instead of the value written before reset. It writes an open-drain pin's latch as 1 and then as 0, which shows whether the pin ever drives high or fails to release. It reads the write-only register and writes to an unmapped offset, then reads the direction register and looks at `pull_en`; a loose address decode shows up as a wrong value in one of them. It also counts edges after a pin change to catch a synchronizer one stage too short or too long, and toggles untapped pins to show whether they wrongly reach `irq_n`.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;
   typedef enum logic [1:0] {
      GP_SEL_NONE = 2'd0,
      GP_SEL_LAT  = 2'd1,
      GP_SEL_DIR  = 2'd2,
      GP_SEL_PINH = 2'd3
   } gp_reg_e;

   function automatic gp_reg_e gp_decode(input logic [7:0] addr,
                                         input logic [7:0] lat_ofs,
                                         input logic [7:0] dir_ofs,
                                         input logic [7:0] pinh_ofs);
      gp_reg_e r;
      if (addr == lat_ofs)       r = GP_SEL_LAT;
      else if (addr == dir_ofs)  r = GP_SEL_DIR;
      else if (addr == pinh_ofs) r = GP_SEL_PINH;
      else                       r = GP_SEL_NONE;
      return r;
   endfunction
endpackage

// File: rtl/gpio_pin_sync.sv
`timescale 1ns/1ps
module gpio_pin_sync #(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("gpio_pin_sync: SYNC_STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg_q [SYNC_STAGES];

   // Synchronizer flops carry no reset so they track the pads at all times.
   always_ff @(posedge clk) begin
      stg_q[0] <= d_async;
      for (int i = 1; i < SYNC_STAGES; i++) begin
         stg_q[i] <= stg_q[i-1];
      end
   end

   assign q_sync = stg_q[LAST];
endmodule

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int               WIDTH    = 8,
   parameter int               ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] LAT_OFS  = 8'h00,
   parameter logic [ADDR_W-1:0] DIR_OFS  = 8'h04,
   parameter logic [ADDR_W-1:0] PINH_OFS = 8'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   input  logic [WIDTH-1:0]  pin_sync,
   output logic [WIDTH-1:0]  bus_rdata,
   output logic [WIDTH-1:0]  lat_q,
   output logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  pinh_q
);
   localparam int DEC_W = 8;

   if (ADDR_W > DEC_W) begin : g_bad_addr
      $error("gpio_port_regs: ADDR_W must not exceed 8");
   end
   if (LAT_OFS == DIR_OFS || LAT_OFS == PINH_OFS || DIR_OFS == PINH_OFS) begin : g_bad_map
      $error("gpio_port_regs: register offsets must be distinct");
   end

   gp_reg_e          sel_e;
   logic             wr_en;
   logic             rd_en;
   logic [DEC_W-1:0] addr_x;
   logic [DEC_W-1:0] lat_x;
   logic [DEC_W-1:0] dir_x;
   logic [DEC_W-1:0] pinh_x;

   assign addr_x = DEC_W'(bus_addr);
   assign lat_x  = DEC_W'(LAT_OFS);
   assign dir_x  = DEC_W'(DIR_OFS);
   assign pinh_x = DEC_W'(PINH_OFS);
   assign sel_e  = gp_decode(addr_x, lat_x, dir_x, pinh_x);
   assign wr_en  = bus_sel & bus_we;
   assign rd_en  = bus_sel & ~bus_we;

   // Output latch: deliberately no reset, contents survive a reset pulse.
   always_ff @(posedge clk) begin
      if (wr_en && sel_e == GP_SEL_LAT) begin
         lat_q <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
      end else if (wr_en && sel_e == GP_SEL_DIR) begin
         dir_q <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pinh_q <= '0;
      end else if (wr_en && sel_e == GP_SEL_PINH) begin
         pinh_q <= bus_wdata;
      end
   end

   // Read path: outputs show the latch, inputs show the synchronized pad.
   always_comb begin
      bus_rdata = '0;
      if (rd_en) begin
         case (sel_e)
            GP_SEL_LAT: bus_rdata = (lat_q & dir_q) | (pin_sync & ~dir_q);
            GP_SEL_DIR: bus_rdata = dir_q;
            default:    bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/gpio_pin_ctrl.sv
`timescale 1ns/1ps
module gpio_pin_ctrl #(
   parameter int               WIDTH     = 8,
   parameter logic [WIDTH-1:0] OD_MASK   = 8'hC0,
   parameter logic [WIDTH-1:0] SLOW_MASK = 8'hC0
) (
   input  logic [WIDTH-1:0] lat_q,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] pinh_q,
   input  logic             slow_edge_en,
   output logic [WIDTH-1:0] pin_oe,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pull_en,
   output logic [WIDTH-1:0] slow_fall
);
   for (genvar b = 0; b < WIDTH; b++) begin : g_pin
      if (OD_MASK[b]) begin : g_od
         // Open-drain: only ever sinks, never drives high.
         assign pin_oe[b]  = dir_q[b] & ~lat_q[b];
         assign pin_out[b] = 1'b0;
      end else begin : g_pp
         assign pin_oe[b]  = dir_q[b];
         assign pin_out[b] = lat_q[b];
      end

      if (SLOW_MASK[b]) begin : g_slow
         assign slow_fall[b] = slow_edge_en & dir_q[b];
      end else begin : g_fast
         assign slow_fall[b] = 1'b0;
      end

      assign pull_en[b] = ~pinh_q[b] & ~dir_q[b];
   end
endmodule

// File: rtl/gpio_irq_tap.sv
`timescale 1ns/1ps
module gpio_irq_tap #(
   parameter int               WIDTH    = 8,
   parameter logic [WIDTH-1:0] IRQ_MASK = 8'h8F
) (
   input  logic [WIDTH-1:0] pin_sync,
   output logic             irq_n
);
   localparam int TAPS = $countones(IRQ_MASK);

   if (TAPS == 0) begin : g_no_taps
      assign irq_n = 1'b1;
   end else begin : g_taps
      logic [WIDTH-1:0] low_hit;
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         if (IRQ_MASK[b]) begin : g_on
            assign low_hit[b] = ~pin_sync[b];
         end else begin : g_off
            assign low_hit[b] = 1'b0;
         end
      end
      // Wired combination of active-low sources.
      assign irq_n = ~|low_hit;
   end
endmodule

// File: rtl/gpio_bidir_port.sv
`timescale 1ns/1ps
module gpio_bidir_port #(
   parameter int               WIDTH       = 8,
   parameter int               ADDR_W      = 8,
   parameter int               SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] LAT_OFS    = 8'h00,
   parameter logic [ADDR_W-1:0] DIR_OFS    = 8'h04,
   parameter logic [ADDR_W-1:0] PINH_OFS   = 8'h10,
   parameter logic [WIDTH-1:0] OD_MASK     = 8'hC0,
   parameter logic [WIDTH-1:0] SLOW_MASK   = 8'hC0,
   parameter logic [WIDTH-1:0] IRQ_MASK    = 8'h8F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_oe,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pull_en,
   input  logic              slow_edge_en,
   output logic [WIDTH-1:0]  slow_fall,
   output logic              irq_n
);
   if (WIDTH < 1 || WIDTH > 8) begin : g_bad_width
      $error("gpio_bidir_port: WIDTH must be 1..8 for a byte bus");
   end

   logic [WIDTH-1:0] pin_sync;
   logic [WIDTH-1:0] lat_q;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] pinh_q;

   gpio_pin_sync #(
      .WIDTH       (WIDTH),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .d_async (pin_in),
      .q_sync  (pin_sync)
   );

   gpio_port_regs #(
      .WIDTH    (WIDTH),
      .ADDR_W   (ADDR_W),
      .LAT_OFS  (LAT_OFS),
      .DIR_OFS  (DIR_OFS),
      .PINH_OFS (PINH_OFS)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .pin_sync  (pin_sync),
      .bus_rdata (bus_rdata),
      .lat_q     (lat_q),
      .dir_q     (dir_q),
      .pinh_q    (pinh_q)
   );

   gpio_pin_ctrl #(
      .WIDTH     (WIDTH),
      .OD_MASK   (OD_MASK),
      .SLOW_MASK (SLOW_MASK)
   ) u_ctrl (
      .lat_q        (lat_q),
      .dir_q        (dir_q),
      .pinh_q       (pinh_q),
      .slow_edge_en (slow_edge_en),
      .pin_oe       (pin_oe),
      .pin_out      (pin_out),
      .pull_en      (pull_en),
      .slow_fall    (slow_fall)
   );

   gpio_irq_tap #(
      .WIDTH    (WIDTH),
      .IRQ_MASK (IRQ_MASK)
   ) u_irq (
      .pin_sync (pin_sync),
      .irq_n    (irq_n)
   );
endmodule

// File: rtl/gpio_bidir_port_chk.sv
`timescale 1ns/1ps
module gpio_bidir_port_chk #(
   parameter int               WIDTH       = 8,
   parameter int               ADDR_W      = 8,
   parameter int               SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] LAT_OFS    = 8'h00,
   parameter logic [ADDR_W-1:0] DIR_OFS    = 8'h04,
   parameter logic [WIDTH-1:0] OD_MASK     = 8'hC0,
   parameter logic [WIDTH-1:0] SLOW_MASK   = 8'hC0,
   parameter logic [WIDTH-1:0] IRQ_MASK    = 8'h8F
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [WIDTH-1:0]  bus_wdata,
   input logic [WIDTH-1:0]  bus_rdata,
   input logic [WIDTH-1:0]  pin_in,
   input logic [WIDTH-1:0]  pin_oe,
   input logic [WIDTH-1:0]  pin_out,
   input logic [WIDTH-1:0]  pull_en,
   input logic              slow_edge_en,
   input logic [WIDTH-1:0]  slow_fall,
   input logic              irq_n,
   input logic [WIDTH-1:0]  lat_q,
   input logic [WIDTH-1:0]  dir_q,
   input logic [WIDTH-1:0]  pinh_q
);
   logic rd_mapped;
   assign rd_mapped = bus_sel && !bus_we && (bus_addr == LAT_OFS || bus_addr == DIR_OFS);

   p_dir_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && bus_addr == DIR_OFS) |=> (dir_q == $past(bus_wdata)));

   p_reset_clear_r3: assert property (@(posedge clk)
      !rst_n |=> (dir_q == '0 && pinh_q == '0));

   p_od_no_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_oe & pin_out & OD_MASK) == '0));

   p_od_sink_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_oe & OD_MASK) == (dir_q & ~lat_q & OD_MASK)));

   p_slow_out_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((slow_fall & ~(dir_q & SLOW_MASK)) == '0));

   p_slow_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !slow_edge_en |-> (slow_fall == '0));

   p_pull_off_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((pull_en & (dir_q | pinh_q)) == '0));

   p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_mapped |-> (bus_rdata == '0));

   if (SYNC_STAGES == 2) begin : g_lat_chk
      p_irq_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
         irq_n == ~|(~$past(pin_in, 2) & IRQ_MASK));
   end
endmodule

bind gpio_bidir_port gpio_bidir_port_chk #(
   .WIDTH       (WIDTH),
   .ADDR_W      (ADDR_W),
   .SYNC_STAGES (SYNC_STAGES),
   .LAT_OFS     (LAT_OFS),
   .DIR_OFS     (DIR_OFS),
   .OD_MASK     (OD_MASK),
   .SLOW_MASK   (SLOW_MASK),
   .IRQ_MASK    (IRQ_MASK)
) u_chk (.*);

// File: tb/sim_gpio_bidir_port.sv
`timescale 1ns/1ps
module sim_gpio_bidir_port;
   localparam int CLK_PERIOD = 10;
   localparam int K_RD   = 0;
   localparam int K_OE   = 1;
   localparam int K_OUT  = 2;
   localparam int K_PULL = 3;
   localparam int K_SLOW = 4;
   localparam int K_IRQ  = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] pin_in = 8'hFF;
   logic [7:0] pin_oe;
   logic [7:0] pin_out;
   logic [7:0] pull_en;
   logic       slow_edge_en = 1'b0;
   logic [7:0] slow_fall;
   logic       irq_n;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   typedef struct {
      int         kind;
      logic [7:0] exp;
      string      tag;
   } exp_t;
   exp_t sb_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_bidir_port u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_sel      (bus_sel),
      .bus_we       (bus_we),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .pin_in       (pin_in),
      .pin_oe       (pin_oe),
      .pin_out      (pin_out),
      .pull_en      (pull_en),
      .slow_edge_en (slow_edge_en),
      .slow_fall    (slow_fall),
      .irq_n        (irq_n)
   );

   // Monitor: compares queued expectations at the falling edge.
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         exp_t it;
         logic [7:0] got;
         it = sb_q.pop_front();
         case (it.kind)
            K_RD:    got = bus_rdata;
            K_OE:    got = pin_oe;
            K_OUT:   got = pin_out;
            K_PULL:  got = pull_en;
            K_SLOW:  got = slow_fall;
            default: got = {7'd0, irq_n};
         endcase
         n_vec++;
         if (got !== it.exp) begin
            n_bad++;
            $display("FAIL %s kind=%0d got=%02h exp=%02h", it.tag, it.kind, got, it.exp);
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic push(input int kind, input logic [7:0] exp, input string tag);
      exp_t it;
      it.kind = kind;
      it.exp  = exp;
      it.tag  = tag;
      sb_q.push_back(it);
   endtask

   task automatic expect_now(input int kind, input logic [7:0] exp, input string tag);
      push(kind, exp, tag);
      step();
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      step();
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      push(K_RD, exp, tag);
      step();
      bus_sel = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      step();
      // R3 / R7 reset state
      expect_now(K_OE,   8'h00, "R3 oe after reset");
      expect_now(K_PULL, 8'hFF, "R7 pulls on after reset");
      expect_now(K_SLOW, 8'h00, "R6 no slow after reset");
      expect_now(K_IRQ,  8'h01, "R9 idle irq high");
      rd(8'h04, 8'h00, "R3 dir cleared");

      wr(8'h00, 8'hA5);
      rd(8'h00, 8'hFF, "R4 inputs read pads");
      wr(8'h04, 8'h0F);
      rd(8'h04, 8'h0F, "R1 dir readback");
      rd(8'h00, 8'hF5, "R4 mixed read");
      expect_now(K_OE,   8'h0F, "R2 oe follows dir");
      expect_now(K_OUT,  8'h25, "R2 out follows latch");
      expect_now(K_PULL, 8'hF0, "R7 pull off on outputs");

      wr(8'h04, 8'hFF);
      expect_now(K_OE,   8'h7F, "R5 pin7 released pin6 sinks");
      expect_now(K_SLOW, 8'h00, "R6 slow gated off");
      slow_edge_en = 1'b1;
      expect_now(K_SLOW, 8'hC0, "R6 slow on upper outputs");
      wr(8'h04, 8'h80);
      expect_now(K_SLOW, 8'h80, "R6 slow needs output");
      expect_now(K_OE,   8'h00, "R5 pin7 latch high released");
      wr(8'h00, 8'h00);
      wr(8'h04, 8'hC0);
      expect_now(K_OE,   8'hC0, "R5 upper pins sink");
      expect_now(K_OUT,  8'h00, "R5 od out stays low");
      wr(8'h00, 8'hA5);
      wr(8'h04, 8'h80);

      wr(8'h10, 8'h33);
      rd(8'h10, 8'h00, "R8 pull-inhibit write-only");
      expect_now(K_PULL, 8'h4C, "R7 inhibit applied");
      wr(8'h08, 8'hFF);
      rd(8'h04, 8'h80, "R8 unmapped write ignored dir");
      expect_now(K_PULL, 8'h4C, "R8 unmapped write ignored pull");
      rd(8'h08, 8'h00, "R8 unmapped read zero");

      rst_n = 1'b0;
      step();
      rst_n = 1'b1;
      step();
      expect_now(K_PULL, 8'hFF, "R3 pull-inhibit cleared");
      rd(8'h04, 8'h00, "R3 dir cleared again");
      wr(8'h04, 8'hFF);
      rd(8'h00, 8'hA5, "R3 latch kept");

      wr(8'h04, 8'h00);
      slow_edge_en = 1'b0;
      pin_in = 8'h8F;
      step(); step(); step();
      expect_now(K_IRQ, 8'h01, "R9 untapped pins ignored");
      pin_in = 8'hFE;
      step();
      push(K_RD, 8'h8F, "R10 one edge old value");
      push(K_IRQ, 8'h01, "R10 irq one edge old");
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 8'h00;
      step();
      push(K_RD, 8'hFE, "R10 two edges new value");
      push(K_IRQ, 8'h00, "R10 irq two edges");
      step();
      bus_sel = 1'b0;
      pin_in = 8'h7F;
      step(); step();
      expect_now(K_IRQ, 8'h00, "R9 pin7 tapped");
      pin_in = 8'hFF;
      step(); step();
      expect_now(K_IRQ, 8'h01, "R9 irq released");

      step();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule